// File: doc/BRIEF.md
# Escape and Timeout Clock Divider

This block sits in the byte-clock domain of a serial display link controller and turns the byte clock into two slower timing sources. The first is an escape-clock enable used to pace low-power lane signalling. It is a square-ish waveform whose period spans a programmable number of byte-clock cycles. The second is a one-cycle timeout tick. Logic that detects errors in the transitions between high-speed and low-power states uses this tick as its unit of time.

Both division factors are 8 bits wide and are packed into one 32-bit configuration word. A write of that word reprograms both dividers at once. A divider whose factor actually changes restarts its count from zero. A divider whose factor is written with the same value keeps its phase. Escape factors 0 and 1 switch the escape output off. A timeout factor of 0 suppresses the tick. For example, with the byte clock at its 125 MHz ceiling, an escape factor of 7 yields an escape rate just under 18 MHz.

Top module: `esc_to_clkdiv`

## Requirements
- R1: After reset the configuration word reads 0, the escape output is low and no tick is produced. A write stores the escape factor from bits 7:0 and the timeout factor from bits 15:8. Both fields read back at the same positions from the cycle after the write.
- R2: Bits 31:16 of the configuration word always read 0, whatever value is written to them.
- R3: While the escape factor is 0 or 1, the escape output stays low.
- R4: For an escape factor N of 2 or more, the escape output repeats with a period of N byte-clock cycles. It is high for the first floor(N/2) cycles of each period and low for the rest, so for odd N the high phase is one cycle shorter than the low phase.
- R5: For a timeout factor N of 1 or more, the tick is high for exactly one cycle in every N. A factor of 1 gives a tick on every cycle.
- R6: While the timeout factor is 0, the tick never fires.
- R7: A write that changes a factor restarts that divider. In the first cycle after the write, the escape output is high (for N ≥ 2). The first tick appears in the N-th cycle after the write.
- R8: A write that leaves a factor unchanged does not disturb that divider's phase.
- R9: Changing one factor does not restart or otherwise disturb the other divider.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Byte clock |
| rst_i | input | 1 | Synchronous active-high reset |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_wdata_i | input | 32 | Configuration write data: bits 7:0 escape factor, bits 15:8 timeout factor |
| cfg_rdata_o | output | 32 | Current configuration word, bits 31:16 always zero |
| esc_clk_o | output | 1 | Divided escape clock enable |
| to_tick_o | output | 1 | Single-cycle timeout tick |

## Verification
Two things can fall in the same cycle: a configuration write and a divider's own wrap. The bench provokes this by timing writes to land on the last count of a period. This happens both for writes that change a factor and for writes that repeat it. A single write also changes both factors together, so that both restarts happen on one edge. A behavioural model is compared with all three outputs on every cycle. Any mismatch between restart and wrap is judged by whether the escape output comes out high, and the tick low, in the cycle after the write.

// File: rtl/esc_to_clkdiv_pkg.sv
package esc_to_clkdiv_pkg;

    // Width of one division factor and of the packed configuration word.
    localparam int DIV_W   = 8;
    localparam int CFG_W   = 32;
    // Field placement inside the configuration word.
    localparam int ESC_LSB = 0;
    localparam int TO_LSB  = ESC_LSB + DIV_W;
    localparam int USED_W  = 2 * DIV_W;

    // Mask of writable bits; everything above USED_W reads as zero.
    localparam logic [CFG_W-1:0] CFG_MASK = CFG_W'((64'd1 << USED_W) - 64'd1);

    typedef logic [DIV_W-1:0] div_t;

    // Decoded configuration.
    typedef struct packed {
        div_t to_div;
        div_t esc_div;
    } clkdiv_cfg_t;

    // Output flavour of a divider instance.
    typedef enum logic {
        DIV_TOGGLE = 1'b0,
        DIV_PULSE  = 1'b1
    } div_mode_t;

    // Smallest factor at which a divider produces output.
    function automatic div_t min_active(input div_mode_t mode);
        return (mode == DIV_TOGGLE) ? div_t'(2) : div_t'(1);
    endfunction

    // Unpack a configuration word into its fields.
    function automatic clkdiv_cfg_t unpack_cfg(input logic [CFG_W-1:0] word);
        clkdiv_cfg_t c;
        c.esc_div = word[ESC_LSB +: DIV_W];
        c.to_div  = word[TO_LSB  +: DIV_W];
        return c;
    endfunction

endpackage

// File: rtl/esc_to_clkdiv_cfg.sv
module esc_to_clkdiv_cfg
    import esc_to_clkdiv_pkg::*;
(
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             we_i,
    input  logic [CFG_W-1:0] wdata_i,
    output clkdiv_cfg_t      cfg_o,
    output logic             esc_restart_o,
    output logic             to_restart_o,
    output logic [CFG_W-1:0] rdata_o
);

    logic [CFG_W-1:0] word_q;
    clkdiv_cfg_t      cur;
    clkdiv_cfg_t      nxt;

    // Unused upper bits are dropped at the write, so they always read zero.
    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            word_q <= '0;
        end else if (we_i) begin
            word_q <= wdata_i & CFG_MASK;
        end
    end

    always_comb begin
        cur = unpack_cfg(word_q);
        nxt = unpack_cfg(wdata_i);
    end

    // A restart is raised only when a written field differs from the held one.
    always_comb begin
        esc_restart_o = we_i && (nxt.esc_div != cur.esc_div);
        to_restart_o  = we_i && (nxt.to_div  != cur.to_div);
    end

    assign cfg_o   = cur;
    assign rdata_o = word_q;

endmodule

// File: rtl/esc_to_clkdiv_div.sv
module esc_to_clkdiv_div
    import esc_to_clkdiv_pkg::*;
#(
    parameter div_mode_t MODE = DIV_TOGGLE,
    parameter int        W    = DIV_W
) (
    input  logic         clk_i,
    input  logic         rst_i,
    input  logic [W-1:0] factor_i,
    input  logic         restart_i,
    output logic         out_o
);

    localparam logic [W-1:0] ONE     = W'(1);
    localparam logic [W-1:0] MIN_ACT = W'(min_active(MODE));

    logic [W-1:0] cnt_q;
    logic         active;
    logic         last;

    always_comb begin
        active = (factor_i >= MIN_ACT);
        last   = active && (cnt_q == factor_i - ONE);
    end

    // Count 0 .. factor-1; hold at zero when stopped or restarted.
    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            cnt_q <= '0;
        end else if (restart_i || !active || last) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + ONE;
        end
    end

    generate
        if (MODE == DIV_TOGGLE) begin : g_toggle
            // High for the first floor(N/2) counts of each period.
            always_comb out_o = active && (cnt_q < (factor_i >> 1));
        end else begin : g_pulse
            // One-cycle pulse on the final count of each period.
            always_comb out_o = last;
        end
    endgenerate

endmodule

// File: rtl/esc_to_clkdiv.sv
module esc_to_clkdiv
    import esc_to_clkdiv_pkg::*;
(
    input  logic        clk_i,
    input  logic        rst_i,
    input  logic        cfg_we_i,
    input  logic [31:0] cfg_wdata_i,
    output logic [31:0] cfg_rdata_o,
    output logic        esc_clk_o,
    output logic        to_tick_o
);

    clkdiv_cfg_t cfg;
    logic        esc_restart;
    logic        to_restart;

    esc_to_clkdiv_cfg u_cfg (
        .clk_i         (clk_i),
        .rst_i         (rst_i),
        .we_i          (cfg_we_i),
        .wdata_i       (cfg_wdata_i),
        .cfg_o         (cfg),
        .esc_restart_o (esc_restart),
        .to_restart_o  (to_restart),
        .rdata_o       (cfg_rdata_o)
    );

    esc_to_clkdiv_div #(
        .MODE (DIV_TOGGLE),
        .W    (DIV_W)
    ) u_esc_div (
        .clk_i     (clk_i),
        .rst_i     (rst_i),
        .factor_i  (cfg.esc_div),
        .restart_i (esc_restart),
        .out_o     (esc_clk_o)
    );

    esc_to_clkdiv_div #(
        .MODE (DIV_PULSE),
        .W    (DIV_W)
    ) u_to_div (
        .clk_i     (clk_i),
        .rst_i     (rst_i),
        .factor_i  (cfg.to_div),
        .restart_i (to_restart),
        .out_o     (to_tick_o)
    );

endmodule

// File: rtl/esc_to_clkdiv_chk.sv
module esc_to_clkdiv_chk (
    input logic        clk_i,
    input logic        rst_i,
    input logic        cfg_we_i,
    input logic [31:0] cfg_wdata_i,
    input logic [31:0] cfg_rdata_o,
    input logic        esc_clk_o,
    input logic        to_tick_o
);

    // R2: upper half never holds anything
    p_upper_zero_r2: assert property (@(posedge clk_i) disable iff (rst_i)
        cfg_rdata_o[31:16] == 16'h0);

    // R1: written low half appears on readback
    p_readback_r1: assert property (@(posedge clk_i) disable iff (rst_i)
        cfg_we_i |=> cfg_rdata_o[15:0] == $past(cfg_wdata_i[15:0]));

    // R3: escape stopped for factors 0 and 1
    p_esc_stop_r3: assert property (@(posedge clk_i) disable iff (rst_i)
        (cfg_rdata_o[7:0] < 8'd2) |-> !esc_clk_o);

    // R4: factor 2 alternates every cycle while untouched
    p_esc_half_r4: assert property (@(posedge clk_i) disable iff (rst_i)
        (cfg_rdata_o[7:0] == 8'd2 && !cfg_we_i) |=> esc_clk_o != $past(esc_clk_o));

    // R5: factor 1 ticks on every cycle
    p_tick_every_r5: assert property (@(posedge clk_i) disable iff (rst_i)
        (cfg_rdata_o[15:8] == 8'd1) |-> to_tick_o);

    // R5: factors above 1 never tick twice in a row
    p_tick_single_r5: assert property (@(posedge clk_i) disable iff (rst_i)
        (to_tick_o && cfg_rdata_o[15:8] >= 8'd2 && !cfg_we_i) |=> !to_tick_o);

    // R6: zero factor suppresses ticks
    p_tick_off_r6: assert property (@(posedge clk_i) disable iff (rst_i)
        (cfg_rdata_o[15:8] == 8'd0) |-> !to_tick_o);

    // R7: changed escape factor of 2 or more starts high
    p_esc_restart_r7: assert property (@(posedge clk_i) disable iff (rst_i)
        (cfg_we_i && cfg_wdata_i[7:0] != cfg_rdata_o[7:0] && cfg_wdata_i[7:0] >= 8'd2)
        |=> esc_clk_o);

    // R7: changed timeout factor of 2 or more gives no tick at once
    p_to_restart_r7: assert property (@(posedge clk_i) disable iff (rst_i)
        (cfg_we_i && cfg_wdata_i[15:8] != cfg_rdata_o[15:8] && cfg_wdata_i[15:8] >= 8'd2)
        |=> !to_tick_o);

endmodule

bind esc_to_clkdiv esc_to_clkdiv_chk u_chk (
    .clk_i       (clk_i),
    .rst_i       (rst_i),
    .cfg_we_i    (cfg_we_i),
    .cfg_wdata_i (cfg_wdata_i),
    .cfg_rdata_o (cfg_rdata_o),
    .esc_clk_o   (esc_clk_o),
    .to_tick_o   (to_tick_o)
);

// File: tb/esc_to_clkdiv_bench.sv
`timescale 1ns/1ps
module esc_to_clkdiv_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        we  = 1'b0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        esc;
    logic        tick;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    string cur_req = "R1";
    bit   done = 1'b0;

    // Behavioural reference state
    int m_esc = 0;
    int m_to  = 0;
    int m_ec  = 0;
    int m_tc  = 0;

    always #5 clk = ~clk;

    esc_to_clkdiv u_esc_to_clkdiv (
        .clk_i       (clk),
        .rst_i       (rst),
        .cfg_we_i    (we),
        .cfg_wdata_i (wdata),
        .cfg_rdata_o (rdata),
        .esc_clk_o   (esc),
        .to_tick_o   (tick)
    );

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h at cycle %0d", req, what, act, exp, cycles);
        end
    endtask

    // Model update on each rising edge.
    always @(posedge clk) begin
        cycles++;
        if (rst) begin
            m_esc = 0; m_to = 0; m_ec = 0; m_tc = 0;
        end else begin
            int ne;
            int nt;
            ne = we ? int'(wdata[7:0])  : m_esc;
            nt = we ? int'(wdata[15:8]) : m_to;
            if (ne != m_esc)      m_ec = 0;
            else if (m_esc < 2)   m_ec = 0;
            else                  m_ec = (m_ec + 1) % m_esc;
            if (nt != m_to)       m_tc = 0;
            else if (m_to == 0)   m_tc = 0;
            else                  m_tc = (m_tc + 1) % m_to;
            m_esc = ne;
            m_to  = nt;
        end
    end

    // Compare every cycle, away from the active edge.
    always @(negedge clk) begin
        if (!rst && !done) begin
            int exp_esc;
            int exp_tick;
            exp_esc  = (m_esc >= 2 && m_ec < m_esc / 2) ? 1 : 0;
            exp_tick = (m_to != 0 && m_tc == m_to - 1) ? 1 : 0;
            check(cur_req, "esc_clk", int'(esc), exp_esc);
            check(cur_req, "to_tick", int'(tick), exp_tick);
            check(cur_req, "rdata", int'(rdata), (m_to << 8) | m_esc);
        end
    end

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic wr(input logic [31:0] d);
        @(negedge clk);
        we = 1'b1;
        wdata = d;
        @(negedge clk);
        we = 1'b0;
        wdata = $urandom();
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    // Watchdog
    always @(posedge clk) begin
        if (cycles > 150000 && !done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual %0d expected below 150000 cycles", cycles);
            finish_run();
        end
    end

    initial begin
        idle(3);
        rst = 1'b0;
        // R1: reset state
        @(negedge clk);
        check("R1", "reset rdata", int'(rdata), 0);
        check("R1", "reset esc", int'(esc), 0);
        check("R1", "reset tick", int'(tick), 0);

        // R1: field placement
        cur_req = "R1";
        wr(32'h0000_0305);
        check("R1", "readback", int'(rdata), 32'h0305);
        idle(12);

        // R2: upper bits ignored
        cur_req = "R2";
        wr(32'hABCD_0407);
        check("R2", "upper readback", int'(rdata), 32'h0407);
        idle(10);

        // R3: escape stopped for 0 and 1
        cur_req = "R3";
        wr(32'h0000_0500);
        idle(12);
        wr(32'h0000_0501);
        idle(12);

        // R4: several escape ratios
        cur_req = "R4";
        for (int n = 2; n <= 9; n++) begin
            wr(32'h0000_0300 | n);
            idle(3 * n + 2);
        end
        wr(32'h0000_03FF);
        idle(520);

        // R5: timeout ratios including 1
        cur_req = "R5";
        wr(32'h0000_0102);
        idle(10);
        wr(32'h0000_0402);
        idle(14);
        wr(32'h0000_0902);
        idle(30);

        // R6: timeout off
        cur_req = "R6";
        wr(32'h0000_0006);
        idle(40);

        // R7: change factors mid-period and on the wrap cycle
        cur_req = "R7";
        wr(32'h0000_0705);
        idle(3);
        wr(32'h0000_0506);
        for (int k = 0; k < 6; k++) begin
            idle(k);
            wr(32'h0000_0600 | (k + 3));
        end
        idle(20);

        // R8: rewrite identical value at various phases
        cur_req = "R8";
        wr(32'h0000_0907);
        for (int k = 0; k < 8; k++) begin
            idle(k + 1);
            wr(32'hFFFF_0907);
        end
        idle(20);

        // R9: change one field only, and both together
        cur_req = "R9";
        wr(32'h0000_0B06);
        idle(4);
        wr(32'h0000_0B04);
        idle(5);
        wr(32'h0000_0704);
        idle(3);
        wr(32'h0000_0509);
        idle(25);

        finish_run();
    end

endmodule